// File: doc/BRIEF.md
# Timer-Aligned Bidirectional Port

This block is an eight-bit general-purpose pin port. Each pin can be made an input or an output, and each output can either push both levels or act as an open-drain line. Software writes output data into a staging register. A commit stage then moves that data to the pins, in one of two ways: one clock after the write, or on the next pulse of an external timer tick. The timer mode lets a program place pin edges exactly on a timer period, whatever the latency of its own bus writes.

Two pins can take the transmit line of one of two serial engines in place of the port data. Two other pins supply synchronized receive taps for the same engines. The register bus is plain: an address, a single-cycle write strobe, write data, and read data that follows the address within the same cycle. It has no back-pressure. A write always lands in the cycle its strobe is sampled, and the pad side has no handshake.

Register map (3-bit address): 0 is data (a write fills the staging register, a read returns the pins), 1 is direction, 2 is drive type, 3 is commit mode, 4 is serial routing.

Top module: `tsp_port`

## Requirements
- R1: After reset every pin is an input (pad_oe all 0) and pad_out is 0. Every configuration register reads 0. The output latch is 0, so setting all directions to output with no data write drives 0x00.
- R2: A pin's pad_oe can be 1 only if its bit in the direction register (address 1, 1 = output) is set. A pin whose direction bit is 0 has pad_oe 0 and pad_out 0.
- R3: A push-pull output pin (its bit in address 2 is 0, direction 1) has pad_oe 1, and pad_out equals its data bit.
- R4: An open-drain output pin (its bit in address 2 is 1) with data 0 gives pad_oe 1 and pad_out 0. With data 1 it gives pad_oe 0. pad_out is never 1 on an open-drain pin.
- R5: In immediate mode (address 3 bit 0 = 0), a write to address 0 reaches the pins on the rising edge after the edge that captures the write. Until then the pins keep the old value.
- R6: In tick mode (address 3 bit 0 = 1), the output latch changes only on an edge where timer_tick is 1 and a write is pending. It then takes the most recent value written. Further tick cycles with no new write leave it unchanged.
- R7: Address 4 bit 0 routes ser_txa onto pin 6, and bit 1 routes ser_txb onto pin 4. A routed pin replaces its latch bit with the transmit level, while direction and drive type still apply. With routing off, the transmit inputs have no effect.
- R8: A read of address 0 returns pad_in delayed through two flip-flops, for every pin regardless of direction.
- R9: ser_rxa follows synchronized pin 7, and ser_rxb follows synchronized pin 5.
- R10: Addresses 1 to 4 read back the values last written (address 3 in bit 0, address 4 in bits 1:0). Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| timer_tick | input | 1 | Commit pulse used in tick mode |
| ser_txa | input | 1 | Transmit level of serial engine A |
| ser_txb | input | 1 | Transmit level of serial engine B |
| ser_rxa | output | 1 | Synchronized receive tap for engine A (pin 7) |
| ser_rxb | output | 1 | Synchronized receive tap for engine B (pin 5) |
| pad_in | input | 8 | Pin input levels |
| pad_out | output | 8 | Pin output levels |
| pad_oe | output | 8 | Pin output enables |

## Verification
The bench builds the block with its default parameters: eight pins, two synchronizer stages, transmit lanes on pins 6 and 4, and receive taps on pins 7 and 5. With these values both routing lanes and both taps sit at the positions the requirements name. The fixed two-stage depth makes the read latency of R8 exact, to the cycle. Commit timing is probed one edge before and one edge after each expected change, in both commit modes.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA   = 3'd0,
    REG_DIR    = 3'd1,
    REG_DRIVE  = 3'd2,
    REG_COMMIT = 3'd3,
    REG_ALT    = 3'd4
  } reg_e;

  localparam int ALT_W = 2;
endpackage

// File: rtl/tsp_sync.sv
module tsp_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/tsp_regs.sv
module tsp_regs
  import tsp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic              tick,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  od_q,
  output logic              tick_mode,
  output logic [ALT_W-1:0]  alt_q,
  output logic [WIDTH-1:0]  latch_q
);
  logic [WIDTH-1:0] stage_q;
  logic             pending_q;
  logic             wr_data;
  logic             commit;

  assign wr_data = wr && (addr == REG_DATA);
  // commit source: next clock, or wait for the timer pulse
  assign commit  = pending_q && (!tick_mode || tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q     <= '0;
      od_q      <= '0;
      tick_mode <= 1'b0;
      alt_q     <= '0;
    end else if (wr) begin
      case (addr)
        REG_DIR:    dir_q     <= wdata;
        REG_DRIVE:  od_q      <= wdata;
        REG_COMMIT: tick_mode <= wdata[0];
        REG_ALT:    alt_q     <= wdata[ALT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q   <= '0;
      latch_q   <= '0;
      pending_q <= 1'b0;
    end else begin
      if (wr_data) stage_q <= wdata;
      if (commit)  latch_q <= stage_q;
      pending_q <= wr_data || (pending_q && !commit);
    end
  end
endmodule

// File: rtl/tsp_pad.sv
module tsp_pad
  import tsp_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int TXA_POS = 6,
  parameter int TXB_POS = 4
) (
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] od_q,
  input  logic [ALT_W-1:0] alt_q,
  input  logic             txa,
  input  logic             txb,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);
  for (genvar b = 0; b < WIDTH; b++) begin : gen_bit
    logic lvl;
    if (b == TXA_POS) begin : g_txa
      assign lvl = alt_q[0] ? txa : latch_q[b];
    end else if (b == TXB_POS) begin : g_txb
      assign lvl = alt_q[1] ? txb : latch_q[b];
    end else begin : g_plain
      assign lvl = latch_q[b];
    end
    // open drain: only a low level is driven
    assign pad_oe[b]  = dir_q[b] & (~od_q[b] | ~lvl);
    assign pad_out[b] = dir_q[b] & ~od_q[b] & lvl;
  end
endmodule

// File: rtl/tsp_port.sv
module tsp_port
  import tsp_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int TXA_POS     = 6,
  parameter int TXB_POS     = 4,
  parameter int RXA_POS     = 7,
  parameter int RXB_POS     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic              timer_tick,
  input  logic              ser_txa,
  input  logic              ser_txb,
  output logic              ser_rxa,
  output logic              ser_rxb,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe
);
  logic [WIDTH-1:0] dir_q, od_q, out_latch, in_sync;
  logic             tick_mode;
  logic [ALT_W-1:0] alt_q;

  tsp_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .tick(timer_tick), .dir_q(dir_q), .od_q(od_q), .tick_mode(tick_mode),
    .alt_q(alt_q), .latch_q(out_latch)
  );

  tsp_pad #(.WIDTH(WIDTH), .TXA_POS(TXA_POS), .TXB_POS(TXB_POS)) u_pad (
    .latch_q(out_latch), .dir_q(dir_q), .od_q(od_q), .alt_q(alt_q),
    .txa(ser_txa), .txb(ser_txb), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  tsp_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(in_sync)
  );

  assign ser_rxa = in_sync[RXA_POS];
  assign ser_rxb = in_sync[RXB_POS];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_DATA:   bus_rdata = in_sync;
      REG_DIR:    bus_rdata = dir_q;
      REG_DRIVE:  bus_rdata = od_q;
      REG_COMMIT: bus_rdata[0] = tick_mode;
      REG_ALT:    bus_rdata[ALT_W-1:0] = alt_q;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tsp_port_checker.sv
module tsp_port_checker
  import tsp_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic              timer_tick,
  input logic [WIDTH-1:0]  pad_in,
  input logic [WIDTH-1:0]  pad_out,
  input logic [WIDTH-1:0]  pad_oe,
  input logic [WIDTH-1:0]  dir_q,
  input logic [WIDTH-1:0]  od_q,
  input logic              tick_mode,
  input logic [WIDTH-1:0]  out_latch,
  input logic [WIDTH-1:0]  in_sync
);
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_input_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & ~dir_q) == '0) && ((pad_out & ~dir_q) == '0));

  p_od_never_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & od_q) == '0);

  p_immediate_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == REG_DATA && !tick_mode) |=> ##1 (out_latch == $past(bus_wdata, 2)));

  p_tick_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_mode && !timer_tick) |=> $stable(out_latch));

  if (STAGES == 2) begin : g_depth
    p_sync_depth_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd2) |-> (in_sync == $past(pad_in, 2)));
  end
endmodule

bind tsp_port tsp_port_checker #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .timer_tick(timer_tick), .pad_in(pad_in),
  .pad_out(pad_out), .pad_oe(pad_oe), .dir_q(dir_q), .od_q(od_q),
  .tick_mode(tick_mode), .out_latch(out_latch), .in_sync(in_sync)
);

// File: tb/tsp_port_bench.sv
module tsp_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       timer_tick = 1'b0;
  logic       ser_txa = 1'b0, ser_txb = 1'b0;
  logic       ser_rxa, ser_rxb;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out, pad_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  string      q_req[$];
  int         q_sel[$];
  logic [7:0] q_exp[$];

  always #2 clk = ~clk;

  tsp_port u_tsp_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timer_tick(timer_tick),
    .ser_txa(ser_txa), .ser_txb(ser_txb), .ser_rxa(ser_rxa), .ser_rxb(ser_rxb),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // monitor: consumes expected items at the falling edge
  always @(negedge clk) begin
    while (q_sel.size() > 0) begin
      automatic string      r = q_req.pop_front();
      automatic int         s = q_sel.pop_front();
      automatic logic [7:0] e = q_exp.pop_front();
      automatic logic [7:0] a;
      case (s)
        0: a = pad_out;
        1: a = pad_oe;
        2: a = bus_rdata;
        default: a = {6'b0, ser_rxb, ser_rxa};
      endcase
      n_cmp++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", r, s, a, e);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic expect_item(input string r, input int s, input logic [7:0] e);
    q_req.push_back(r); q_sel.push_back(s); q_exp.push_back(e);
  endtask

  task automatic settle();
    @(negedge clk);
    #0.5;
  endtask

  task automatic rd_check(input string r, input logic [2:0] a, input logic [7:0] e);
    bus_addr = a;
    expect_item(r, 2, e);
    settle();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    // R1 reset state
    expect_item("R1", 1, 8'h00); expect_item("R1", 0, 8'h00); settle();
    rd_check("R1", 3'd1, 8'h00);
    rd_check("R1", 3'd4, 8'h00);
    wr(3'd1, 8'hFF);
    expect_item("R1", 0, 8'h00); expect_item("R3", 1, 8'hFF); settle();

    // R5 immediate commit latency
    wr(3'd0, 8'hA5);
    expect_item("R5", 0, 8'h00); settle();
    step();
    expect_item("R5", 0, 8'hA5); expect_item("R3", 0, 8'hA5); settle();

    // R6 tick mode
    wr(3'd3, 8'h01);
    wr(3'd0, 8'h3C);
    step(); step(); step();
    expect_item("R6", 0, 8'hA5); settle();
    timer_tick = 1'b1; step(); timer_tick = 1'b0;
    expect_item("R6", 0, 8'h3C); settle();
    wr(3'd0, 8'h11);
    wr(3'd0, 8'h22);
    step();
    expect_item("R6", 0, 8'h3C); settle();
    timer_tick = 1'b1; step();
    expect_item("R6", 0, 8'h22); settle();
    step(); step(); timer_tick = 1'b0;
    expect_item("R6", 0, 8'h22); settle();

    // R4 open drain
    wr(3'd3, 8'h00);
    wr(3'd2, 8'hFF);
    wr(3'd0, 8'h5A);
    step();
    expect_item("R4", 1, 8'hA5); expect_item("R4", 0, 8'h00); settle();

    // R2 direction mask, push-pull
    wr(3'd2, 8'h00);
    wr(3'd1, 8'h0F);
    expect_item("R2", 1, 8'h0F); expect_item("R2", 0, 8'h0A); settle();

    // R7 serial routing
    wr(3'd1, 8'hFF);
    wr(3'd0, 8'h00);
    step();
    ser_txa = 1'b1;
    expect_item("R7", 0, 8'h00); settle();
    wr(3'd4, 8'h01);
    expect_item("R7", 0, 8'h40); settle();
    ser_txb = 1'b1;
    wr(3'd4, 8'h03);
    expect_item("R7", 0, 8'h50); settle();
    ser_txa = 1'b0;
    expect_item("R7", 0, 8'h10); settle();
    wr(3'd2, 8'h10);
    expect_item("R7", 1, 8'hEF); expect_item("R7", 0, 8'h00); settle();

    // R8 input synchronizer depth
    bus_addr = 3'd0;
    pad_in = 8'hC3;
    step();
    rd_check("R8", 3'd0, 8'h00);
    step();
    rd_check("R8", 3'd0, 8'hC3);

    // R9 receive taps
    pad_in = 8'h80; step(); step();
    expect_item("R9", 3, 8'h01); settle();
    pad_in = 8'h20; step(); step();
    expect_item("R9", 3, 8'h02); settle();

    // R10 readback
    rd_check("R10", 3'd1, 8'hFF);
    rd_check("R10", 3'd2, 8'h10);
    rd_check("R10", 3'd3, 8'h00);
    rd_check("R10", 3'd4, 8'h03);
    rd_check("R10", 3'd6, 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule